// File: doc/BRIEF.md
# Masked-Write GPIO Controller

This block is a general-purpose pin controller with a small word-addressed register interface. It owns the output value and output-enable state for every pin. Software can write that state as a whole word. It can also write one half of the pins at a time, through an alias whose upper sixteen bits choose which pins change. Because of these aliases, one pin can be set or cleared in a single write, with no read-modify-write and no race against other agents that touch neighbouring pins.

On the input side, each pin is brought into the clock domain through a flop chain. A per-pin debounce filter can be switched in or out. Every pin can raise four kinds of event: rising edge, falling edge, high level and low level. Each kind has its own per-pin enable. Events latch into a sticky pending register, which software clears by writing ones. A force register lets software raise pending bits directly. A single interrupt line reports any pending bit whose interrupt enable is set.

The bus is a plain strobe interface. A write takes effect at the clock edge where `wr_en_i` is high. Read data is combinational from `addr_i` while `rd_en_i` is high, and zero otherwise. `addr_i` is a word index.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset, every pin is an input driving 0, `irq_o` is low, and reads of the pending, interrupt-enable, output and output-enable registers return 0.
- R2: A write to word 9 (full output) or word 12 (full output enable) replaces all pin bits. The new value drives `pins_o` / `pins_oe_o` from the next cycle and reads back from the same word. Without a write, neither output changes.
- R3: Words 10 (output, pins 0-15) and 13 (output enable, pins 0-15) take new values in bits 15:0 and a mask in bits 31:16. Pin i changes to data bit i only where mask bit 16+i is 1. All other pins keep their value.
- R4: Words 11 (output, pins 16-31) and 14 (output enable, pins 16-31) use the same data/mask layout. Data bit k and mask bit 16+k apply to pin 16+k, and pins 0-15 are untouched.
- R5: A read of a half alias returns that half's current state in bits 15:0 and zero in bits 31:16. The full word 9/12 always shows the result of masked writes.
- R6: Word 3 (read-only) shows the pin levels after a two-flop synchroniser. With the filter off, a change at the pin appears after the second rising clock edge and not after the first.
- R7: Word 8 enables the filter per pin. A filtered pin's level changes only after the synchronised input has held the new value for 16 consecutive clocks, so shorter pulses are ignored.
- R8: Words 4 (rising) and 5 (falling) enable edge events per pin. An enabled edge sets that pin's bit in word 0 (pending) within three clock edges of the pin change. An edge that is not enabled sets nothing.
- R9: Words 6 (high level) and 7 (low level) enable level events. The pending bit is set on every cycle the enabled level holds, so a clear write during the level leaves the bit set.
- R10: Pending bits are sticky. Writing 1 to a bit of word 0 clears it, and writing 0 leaves it unchanged.
- R11: Writing 1 to a bit of word 2 (force) sets the matching pending bit. Word 2 always reads 0.
- R12: `irq_o` is high exactly when some pending bit has its bit set in word 1 (interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (zero when not reading) |
| pins_i | input | 32 | Raw pin inputs |
| pins_o | output | 32 | Pin output values |
| pins_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 32 pins, a two-stage synchroniser, a 16-clock filter and the filter variant present. With 32 pins both half aliases map onto real pins, so random mask patterns exercise the lower/upper boundary at pin 16. With the filter length at 16, the bench can place the exact clock on which a filtered pin first flips and the last clock on which it has not. The two-stage chain fixes input latency at two edges, which lets the bench catch an off-by-one in the synchroniser.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
   localparam int REG_W    = 32;
   localparam int MASK_LSB = 16;
   localparam int ADDR_W   = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_PEND   = 4'd0,
      A_IEN    = 4'd1,
      A_FORCE  = 4'd2,
      A_IN     = 4'd3,
      A_RISE   = 4'd4,
      A_FALL   = 4'd5,
      A_HIGH   = 4'd6,
      A_LOW    = 4'd7,
      A_FILT   = 4'd8,
      A_OUT    = 4'd9,
      A_OUT_LO = 4'd10,
      A_OUT_HI = 4'd11,
      A_OE     = 4'd12,
      A_OE_LO  = 4'd13,
      A_OE_HI  = 4'd14
   } gpm_reg_e;
endpackage

// File: rtl/gpm_sync_filter.sv
module gpm_sync_filter #(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 16,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] raw_i,
   input  logic [NUM_PINS-1:0] filt_en_i,
   output logic [NUM_PINS-1:0] level_o
);
   localparam int CNT_W = $clog2(FILT_LEN);

   logic [NUM_PINS-1:0] sync_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] synced;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      end else begin
         sync_q[0] <= raw_i;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (USE_FILTER) begin : g_filt
         for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [CNT_W-1:0] cnt_q;
            logic             stable_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  cnt_q    <= '0;
                  stable_q <= 1'b0;
               end else if (synced[p] == stable_q) begin
                  cnt_q <= '0;
               end else if (cnt_q == CNT_W'(FILT_LEN-1)) begin
                  cnt_q    <= '0;
                  stable_q <= synced[p];
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end

            assign level_o[p] = filt_en_i[p] ? stable_q : synced[p];
         end
      end else begin : g_nofilt
         logic unused_en;
         assign unused_en = ^filt_en_i;
         assign level_o   = synced;
      end
   endgenerate
endmodule

// File: rtl/gpm_event_detect.sv
module gpm_event_detect #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] rise_en_i,
   input  logic [NUM_PINS-1:0] fall_en_i,
   input  logic [NUM_PINS-1:0] high_en_i,
   input  logic [NUM_PINS-1:0] low_en_i,
   input  logic [NUM_PINS-1:0] clr_i,
   input  logic [NUM_PINS-1:0] force_i,
   output logic [NUM_PINS-1:0] pend_o
);
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] hit;

   // Hardware set wins over a clear in the same cycle.
   always_comb begin
      hit = (level_i & ~prev_q & rise_en_i)
          | (~level_i & prev_q & fall_en_i)
          | (level_i & high_en_i)
          | (~level_i & low_en_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         pend_o <= '0;
      end else begin
         prev_q <= level_i;
         pend_o <= (pend_o & ~clr_i) | hit | force_i;
      end
   end
endmodule

// File: rtl/gpm_mask_reg.sv
module gpm_mask_reg #(
   parameter int NUM_PINS = 32,
   parameter int REG_W    = 32,
   parameter int MASK_LSB = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_full_i,
   input  logic                wr_lo_i,
   input  logic                wr_hi_i,
   input  logic [REG_W-1:0]    wdata_i,
   output logic [NUM_PINS-1:0] q_o
);
   localparam int HALF = NUM_PINS / 2;

   logic [HALF-1:0]     m_data;
   logic [HALF-1:0]     m_sel;
   logic [NUM_PINS-1:0] nxt;

   assign m_data = wdata_i[HALF-1:0];
   assign m_sel  = wdata_i[MASK_LSB +: HALF];

   always_comb begin
      nxt = q_o;
      if (wr_full_i) nxt = wdata_i[NUM_PINS-1:0];
      if (wr_lo_i)   nxt[HALF-1:0] = (q_o[HALF-1:0] & ~m_sel) | (m_data & m_sel);
      if (wr_hi_i)   nxt[NUM_PINS-1:HALF] = (q_o[NUM_PINS-1:HALF] & ~m_sel) | (m_data & m_sel);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= nxt;
   end
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
   import gpm_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 16,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [REG_W-1:0]    wdata_i,
   output logic [REG_W-1:0]    rdata_o,
   input  logic [NUM_PINS-1:0] pins_i,
   output logic [NUM_PINS-1:0] pins_o,
   output logic [NUM_PINS-1:0] pins_oe_o,
   output logic                irq_o
);
   localparam int HALF = NUM_PINS / 2;

   generate
      if (NUM_PINS < 2 || NUM_PINS > REG_W || (NUM_PINS % 2) != 0) begin : g_bad_pins
         $error("NUM_PINS must be even and between 2 and 32");
      end
      if (HALF > MASK_LSB) begin : g_bad_half
         $error("half alias does not fit below the mask field");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 2) begin : g_bad_filt
         $error("FILT_LEN must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] ien_q, rise_q, fall_q, high_q, low_q, filt_q;
   logic [NUM_PINS-1:0] level, pend, clr, frc;

   function automatic logic wsel(input logic we, input logic [ADDR_W-1:0] a, input gpm_reg_e r);
      return we && (a == r);
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         high_q <= '0;
         low_q  <= '0;
         filt_q <= '0;
      end else begin
         if (wsel(wr_en_i, addr_i, A_IEN))  ien_q  <= wdata_i[NUM_PINS-1:0];
         if (wsel(wr_en_i, addr_i, A_RISE)) rise_q <= wdata_i[NUM_PINS-1:0];
         if (wsel(wr_en_i, addr_i, A_FALL)) fall_q <= wdata_i[NUM_PINS-1:0];
         if (wsel(wr_en_i, addr_i, A_HIGH)) high_q <= wdata_i[NUM_PINS-1:0];
         if (wsel(wr_en_i, addr_i, A_LOW))  low_q  <= wdata_i[NUM_PINS-1:0];
         if (wsel(wr_en_i, addr_i, A_FILT)) filt_q <= wdata_i[NUM_PINS-1:0];
      end
   end

   assign clr = wsel(wr_en_i, addr_i, A_PEND)  ? wdata_i[NUM_PINS-1:0] : '0;
   assign frc = wsel(wr_en_i, addr_i, A_FORCE) ? wdata_i[NUM_PINS-1:0] : '0;

   gpm_mask_reg #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .MASK_LSB(MASK_LSB)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_full_i (wsel(wr_en_i, addr_i, A_OUT)),
      .wr_lo_i   (wsel(wr_en_i, addr_i, A_OUT_LO)),
      .wr_hi_i   (wsel(wr_en_i, addr_i, A_OUT_HI)),
      .wdata_i   (wdata_i),
      .q_o       (pins_o)
   );

   gpm_mask_reg #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .MASK_LSB(MASK_LSB)) u_oe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_full_i (wsel(wr_en_i, addr_i, A_OE)),
      .wr_lo_i   (wsel(wr_en_i, addr_i, A_OE_LO)),
      .wr_hi_i   (wsel(wr_en_i, addr_i, A_OE_HI)),
      .wdata_i   (wdata_i),
      .q_o       (pins_oe_o)
   );

   gpm_sync_filter #(
      .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN(FILT_LEN), .USE_FILTER(USE_FILTER)
   ) u_in (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (pins_i),
      .filt_en_i (filt_q),
      .level_o   (level)
   );

   gpm_event_detect #(.NUM_PINS(NUM_PINS)) u_evt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .level_i   (level),
      .rise_en_i (rise_q),
      .fall_en_i (fall_q),
      .high_en_i (high_q),
      .low_en_i  (low_q),
      .clr_i     (clr),
      .force_i   (frc),
      .pend_o    (pend)
   );

   assign irq_o = |(pend & ien_q);

   logic [REG_W-1:0] rmux;
   always_comb begin
      rmux = '0;
      case (addr_i)
         A_PEND:   rmux = REG_W'(pend);
         A_IEN:    rmux = REG_W'(ien_q);
         A_IN:     rmux = REG_W'(level);
         A_RISE:   rmux = REG_W'(rise_q);
         A_FALL:   rmux = REG_W'(fall_q);
         A_HIGH:   rmux = REG_W'(high_q);
         A_LOW:    rmux = REG_W'(low_q);
         A_FILT:   rmux = REG_W'(filt_q);
         A_OUT:    rmux = REG_W'(pins_o);
         A_OUT_LO: rmux = REG_W'(pins_o[HALF-1:0]);
         A_OUT_HI: rmux = REG_W'(pins_o[NUM_PINS-1:HALF]);
         A_OE:     rmux = REG_W'(pins_oe_o);
         A_OE_LO:  rmux = REG_W'(pins_oe_o[HALF-1:0]);
         A_OE_HI:  rmux = REG_W'(pins_oe_o[NUM_PINS-1:HALF]);
         default:  rmux = '0;
      endcase
   end

   assign rdata_o = rd_en_i ? rmux : '0;
endmodule

// File: rtl/gpm_ctrl_chk.sv
module gpm_ctrl_chk
   import gpm_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_en_i,
   input logic [ADDR_W-1:0]   addr_i,
   input logic [REG_W-1:0]    wdata_i,
   input logic [NUM_PINS-1:0] pins_o,
   input logic [NUM_PINS-1:0] pins_oe_o,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] ien_q,
   input logic                irq_o
);
   localparam int HALF = NUM_PINS / 2;

   // R2: outputs hold between writes
   a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(pins_o) && $stable(pins_oe_o)));

   // R3: lower output alias touches only masked lower pins
   a_r3_lo_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_OUT_LO) |=>
         ((((pins_o[HALF-1:0] ^ $past(pins_o[HALF-1:0])) & ~$past(wdata_i[MASK_LSB +: HALF])) == '0)
          && (pins_o[NUM_PINS-1:HALF] == $past(pins_o[NUM_PINS-1:HALF]))));

   // R4: upper enable alias touches only masked upper pins
   a_r4_hi_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_OE_HI) |=>
         ((((pins_oe_o[NUM_PINS-1:HALF] ^ $past(pins_oe_o[NUM_PINS-1:HALF])) & ~$past(wdata_i[MASK_LSB +: HALF])) == '0)
          && (pins_oe_o[HALF-1:0] == $past(pins_oe_o[HALF-1:0]))));

   // R10: pending bits only fall on a clear write
   a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == A_PEND) |=> (($past(pend) & ~pend) == '0));

   // R11: force write sets every requested bit
   a_r11_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_FORCE) |=>
         ((pend & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));

   // R12: no enabled source, no interrupt
   a_r12_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_q == '0) |-> !irq_o);
endmodule

bind gpio_mask_ctrl gpm_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_en_i   (wr_en_i),
   .addr_i    (addr_i),
   .wdata_i   (wdata_i),
   .pins_o    (pins_o),
   .pins_oe_o (pins_oe_o),
   .pend      (pend),
   .ien_q     (ien_q),
   .irq_o     (irq_o)
);

// File: tb/gpio_mask_ctrl_tb.sv
module gpio_mask_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pins_in = '0;
   logic [31:0] pins_out, pins_oe;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m_out = '0;
   logic [31:0] m_oe = '0;
   logic [31:0] rv;

   always #5 clk = ~clk;

   gpio_mask_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .pins_i(pins_in), .pins_o(pins_out), .pins_oe_o(pins_oe), .irq_o(irq)
   );

   function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] w, input bit hi);
      logic [31:0] r = cur;
      for (int k = 0; k < 16; k++)
         if (w[16+k]) r[hi ? 16+k : k] = w[k];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      peek(a, d);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 pins_o", pins_out, 32'h0);
      chk("R1 pins_oe", pins_oe, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(4'd0, rv);  chk("R1 pend", rv, 32'h0);
      rd(4'd1, rv);  chk("R1 ien", rv, 32'h0);
      rd(4'd9, rv);  chk("R1 out", rv, 32'h0);
      rd(4'd12, rv); chk("R1 oe", rv, 32'h0);

      // directed boundary masks: pin 15 and pin 16
      wr(4'd10, 32'h8000_8000); m_out = merge(m_out, 32'h8000_8000, 1'b0);
      chk("R3 pin15", pins_out, m_out);
      wr(4'd11, 32'h0001_0001); m_out = merge(m_out, 32'h0001_0001, 1'b1);
      chk("R4 pin16", pins_out, m_out);
      wr(4'd13, 32'h0000_FFFF);
      chk("R3 zero mask", pins_oe, m_oe);

      // R2..R5 random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [31:0] d;
         op = $urandom % 6;
         d  = $urandom;
         case (op)
            0: begin wr(4'd9,  d); m_out = d; chk("R2 out", pins_out, m_out); end
            1: begin wr(4'd10, d); m_out = merge(m_out, d, 1'b0); chk("R3 out lo", pins_out, m_out); end
            2: begin wr(4'd11, d); m_out = merge(m_out, d, 1'b1); chk("R4 out hi", pins_out, m_out); end
            3: begin wr(4'd12, d); m_oe = d; chk("R2 oe", pins_oe, m_oe); end
            4: begin wr(4'd13, d); m_oe = merge(m_oe, d, 1'b0); chk("R3 oe lo", pins_oe, m_oe); end
            default: begin wr(4'd14, d); m_oe = merge(m_oe, d, 1'b1); chk("R4 oe hi", pins_oe, m_oe); end
         endcase
         if (i % 8 == 0) begin
            rd(4'd9,  rv); chk("R5 out full", rv, m_out);
            rd(4'd10, rv); chk("R5 out lo", rv, {16'h0, m_out[15:0]});
            rd(4'd11, rv); chk("R5 out hi", rv, {16'h0, m_out[31:16]});
            rd(4'd12, rv); chk("R5 oe full", rv, m_oe);
            rd(4'd14, rv); chk("R5 oe hi", rv, {16'h0, m_oe[31:16]});
            rd(4'd13, rv); chk("R5 oe lo", rv, {16'h0, m_oe[15:0]});
         end
      end
      repeat (3) @(posedge clk);
      chk("R2 idle hold", pins_out, m_out);

      // R6 synchroniser latency on pin 20
      @(negedge clk); pins_in[20] = 1'b1;
      @(posedge clk); #1 peek(4'd3, rv); chk("R6 after 1 edge", rv & 32'h0010_0000, 32'h0);
      @(posedge clk); #1 peek(4'd3, rv); chk("R6 after 2 edges", rv & 32'h0010_0000, 32'h0010_0000);

      // R7 filter on pin 12
      wr(4'd8, 32'h0000_1000);
      @(negedge clk); pins_in[12] = 1'b1;
      repeat (10) @(negedge clk);
      pins_in[12] = 1'b0;
      repeat (30) @(negedge clk);
      peek(4'd3, rv); chk("R7 glitch ignored", rv & 32'h0000_1000, 32'h0);
      @(negedge clk); pins_in[12] = 1'b1;
      repeat (17) @(posedge clk);
      #1 peek(4'd3, rv); chk("R7 edge 17", rv & 32'h0000_1000, 32'h0);
      @(posedge clk); #1 peek(4'd3, rv); chk("R7 edge 18", rv & 32'h0000_1000, 32'h0000_1000);

      // R8 rising edge on pin 3
      wr(4'd4, 32'h0000_0008);
      wr(4'd1, 32'h0000_0008);
      @(negedge clk); pins_in[3] = 1'b1;
      repeat (4) @(posedge clk);
      rd(4'd0, rv); chk("R8 rise", rv, 32'h0000_0008);
      chk("R12 irq on", {31'b0, irq}, 32'h1);
      wr(4'd0, 32'h0);
      rd(4'd0, rv); chk("R10 write zero keeps", rv, 32'h0000_0008);
      wr(4'd0, 32'h0000_0008);
      rd(4'd0, rv); chk("R10 w1c", rv, 32'h0);
      chk("R12 irq off", {31'b0, irq}, 32'h0);

      // R8 falling edge on pin 5
      wr(4'd5, 32'h0000_0020);
      @(negedge clk); pins_in[5] = 1'b1;
      repeat (4) @(posedge clk);
      rd(4'd0, rv); chk("R8 rise not enabled", rv, 32'h0);
      @(negedge clk); pins_in[5] = 1'b0;
      repeat (4) @(posedge clk);
      rd(4'd0, rv); chk("R8 fall", rv, 32'h0000_0020);
      wr(4'd0, 32'h0000_0020);

      // R9 level high on pin 7
      wr(4'd6, 32'h0000_0080);
      @(negedge clk); pins_in[7] = 1'b1;
      repeat (4) @(posedge clk);
      rd(4'd0, rv); chk("R9 high", rv, 32'h0000_0080);
      wr(4'd0, 32'h0000_0080);
      rd(4'd0, rv); chk("R9 re-set while high", rv, 32'h0000_0080);
      @(negedge clk); pins_in[7] = 1'b0;
      repeat (4) @(posedge clk);
      wr(4'd0, 32'h0000_0080);
      rd(4'd0, rv); chk("R9 cleared after level", rv, 32'h0);

      // R9 level low on pin 9
      wr(4'd7, 32'h0000_0200);
      repeat (2) @(posedge clk);
      rd(4'd0, rv); chk("R9 low", rv, 32'h0000_0200);
      wr(4'd7, 32'h0);
      wr(4'd0, 32'h0000_0200);
      rd(4'd0, rv); chk("R10 low cleared", rv, 32'h0);

      // R11 force, R12 gating
      wr(4'd1, 32'h0);
      wr(4'd2, 32'h8000_0001);
      rd(4'd0, rv); chk("R11 force sets", rv, 32'h8000_0001);
      chk("R12 masked irq", {31'b0, irq}, 32'h0);
      rd(4'd2, rv); chk("R11 force reads 0", rv, 32'h0);
      wr(4'd1, 32'h8000_0000);
      chk("R12 enabled irq", {31'b0, irq}, 32'h1);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, rv); chk("R10 clear all", rv, 32'h0);
      chk("R12 irq drops", {31'b0, irq}, 32'h0);

      finish_run();
   end
endmodule